// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Generator

This block carries out the acknowledge bus cycle that a processor core runs once it has decided to take an interrupt. The core gives it a one-cycle start pulse and the 3-bit priority level being served. The block then opens a bus cycle in CPU space. All function code lines are high. The level sits on the three lowest address lines and every other address line is high, so external decode can tell this reference apart from a normal memory access.

The cycle stays open until one of three responses comes back. The interrupting device can place its own vector byte on the data lines and acknowledge. External logic can raise the valid-peripheral-address input, which here only means "use the auto-vector". Or external logic can signal a bus error, which marks the interrupt as spurious. The block turns whichever response wins into one 8-bit vector number. It returns that number with a one-clock done strobe and releases the bus.

Top module: `iack_vector_gen`

## Requirements
- R1: While reset is applied and just after it, the bus is idle. That means bus_active is 0, bus_fc is 0 and bus_addr is 0. Also vec_num is 0 and vec_done is 0.
- R2: A start pulse with a nonzero level, sampled at a clock edge while idle, opens the bus cycle at that edge. In the open cycle bus_active is 1 and bus_fc is 3'b111. bus_addr[2:0] holds the level and all higher bus_addr bits are 1.
- R3: A start pulse with level 0 is ignored. The bus stays idle.
- R4: If dev_ack alone ends the cycle, vec_num becomes the byte on dev_data.
- R5: If auto_req ends the cycle, vec_num becomes 24 plus the level (levels 1 to 7 give 25 to 31). dev_data is ignored.
- R6: If bus_err ends the cycle, vec_num becomes the spurious vector 24.
- R7: When several responses arrive at the same edge, bus_err wins over auto_req, and auto_req wins over dev_ack.
- R8: The response edge sets vec_done to 1 for exactly one clock and drops bus_active at that same edge. vec_num keeps its value until the next cycle's response edge.
- R9: A start pulse that arrives while a cycle is open is ignored. The level on the bus does not change.
- R10: With no response, the cycle stays open for as long as it takes, and vec_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_start | input | 1 | Start pulse from the core |
| ack_level | input | 3 | Level being acknowledged |
| bus_active | output | 1 | Acknowledge cycle open |
| bus_fc | output | 3 | Function code (all ones in CPU space) |
| bus_addr | output | 23 | Address lines A23..A1; bit 0 is A1 |
| dev_data | input | 8 | Vector byte from the device |
| dev_ack | input | 1 | Device data acknowledge |
| auto_req | input | 1 | Auto-vector request (valid peripheral address) |
| bus_err | input | 1 | Bus error termination |
| vec_num | output | 8 | Resolved vector number |
| vec_done | output | 1 | One-clock completion strobe |

## Verification
The bench targets same-edge collisions of the three responses in every combination. A design with the priority wrong returns the device byte or the auto-vector where 24 is due. It also checks that the auto-vector ignores a deliberately misleading data byte, which catches a design that mixes the data bus into the result. It drives level 0 and level 7, and it sends a second start mid-cycle, which catches level latches that are wrong or can be overwritten. Long stalls with no response show whether a design times out or fires the done strobe on its own.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int LVL_W = 3;
  localparam int VEC_W = 8;
  localparam int FC_W  = 3;

  localparam logic [FC_W-1:0] FC_CPU_SPACE = '1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } iack_state_e;

  typedef enum logic [1:0] {
    TERM_NONE = 2'd0,
    TERM_DATA = 2'd1,
    TERM_AUTO = 2'd2,
    TERM_SPUR = 2'd3
  } iack_term_e;
endpackage

// File: rtl/iack_rst_sync.sv
module iack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
  import iack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic level_nz_i,
  input  logic term_any_i,
  output logic busy_o,
  output logic load_lvl_o,
  output logic finish_o
);
  iack_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_lvl_o = 1'b0;
    finish_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && level_nz_i) begin
          state_d    = ST_BUS;
          load_lvl_o = 1'b1;
        end
      end
      ST_BUS: begin
        if (term_any_i) begin
          state_d  = ST_IDLE;
          finish_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = (state_q == ST_BUS);
endmodule

// File: rtl/iack_addr_gen.sv
module iack_addr_gen
  import iack_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              busy_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [FC_W-1:0]   fc_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (load_i) lvl_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level_o = lvl_q;
  assign fc_o    = busy_i ? FC_CPU_SPACE : '0;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
    if (i < LVL_W) begin : g_lvl
      assign addr_o[i] = busy_i & lvl_q[i];
    end else begin : g_one
      assign addr_o[i] = busy_i;
    end
  end
endmodule

// File: rtl/iack_resolve.sv
module iack_resolve
  import iack_pkg::*;
#(
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             finish_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] dev_data_i,
  input  logic             dev_ack_i,
  input  logic             auto_req_i,
  input  logic             bus_err_i,
  output logic             term_any_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             done_o
);
  localparam logic [VEC_W-1:0] AUTO_B = VEC_W'(AUTO_BASE);
  localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);

  iack_term_e       term;
  logic [VEC_W-1:0] pick;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             done_q, done_d;

  always_comb begin
    term = TERM_NONE;
    if (busy_i) begin
      if (bus_err_i)       term = TERM_SPUR;
      else if (auto_req_i) term = TERM_AUTO;
      else if (dev_ack_i)  term = TERM_DATA;
    end
  end

  always_comb begin
    case (term)
      TERM_SPUR: pick = SPUR_V;
      TERM_AUTO: pick = AUTO_B + {{(VEC_W-LVL_W){1'b0}}, level_i};
      TERM_DATA: pick = dev_data_i;
      default:   pick = vec_q;
    endcase
  end

  assign term_any_o = (term != TERM_NONE);

  always_comb begin
    vec_d  = vec_q;
    done_d = finish_i;
    if (finish_i) vec_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vec_q  <= vec_d;
      done_q <= done_d;
    end
  end

  assign vec_o  = vec_q;
  assign done_o = done_q;
endmodule

// File: rtl/iack_vector_gen.sv
module iack_vector_gen
  import iack_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_start,
  input  logic [2:0]        ack_level,
  output logic              bus_active,
  output logic [2:0]        bus_fc,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        dev_data,
  input  logic              dev_ack,
  input  logic              auto_req,
  input  logic              bus_err,
  output logic [7:0]        vec_num,
  output logic              vec_done
);
  logic             rst_sync_n;
  logic             busy;
  logic             load_lvl;
  logic             finish;
  logic             term_any;
  logic [LVL_W-1:0] lvl_held;

  iack_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  iack_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (ack_start),
    .level_nz_i (ack_level != '0),
    .term_any_i (term_any),
    .busy_o     (busy),
    .load_lvl_o (load_lvl),
    .finish_o   (finish)
  );

  iack_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (load_lvl),
    .level_i (ack_level),
    .busy_i  (busy),
    .level_o (lvl_held),
    .fc_o    (bus_fc),
    .addr_o  (bus_addr)
  );

  iack_resolve #(.AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)) res_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .busy_i     (busy),
    .finish_i   (finish),
    .level_i    (lvl_held),
    .dev_data_i (dev_data),
    .dev_ack_i  (dev_ack),
    .auto_req_i (auto_req),
    .bus_err_i  (bus_err),
    .term_any_o (term_any),
    .vec_o      (vec_num),
    .done_o     (vec_done)
  );

  assign bus_active = busy;
endmodule

// File: rtl/iack_vector_gen_chk.sv
module iack_vector_gen_chk #(
  parameter int ADDR_W    = 23,
  parameter int AUTO_BASE = 24,
  parameter int SPUR_VEC  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_start,
  input logic [2:0]        ack_level,
  input logic              bus_active,
  input logic [2:0]        bus_fc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        dev_data,
  input logic              dev_ack,
  input logic              auto_req,
  input logic              bus_err,
  input logic [7:0]        vec_num,
  input logic              vec_done
);
  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> (bus_fc == 3'b000 && bus_addr == '0));
  // R2
  cpu_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> (bus_fc == 3'b111 && bus_addr[ADDR_W-1:3] == '1 && bus_addr[2:0] != 3'b000));
  // R3
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_active && ack_start && ack_level == 3'b000) |=> !bus_active);
  // R4
  dev_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && dev_ack && !auto_req && !bus_err) |=> (vec_done && vec_num == $past(dev_data)));
  // R5
  auto_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && auto_req && !bus_err) |=> (vec_done && vec_num == 8'(AUTO_BASE) + {5'b0, $past(bus_addr[2:0])}));
  // R6
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_err) |=> (vec_done && vec_num == 8'(SPUR_VEC)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> !vec_done);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |-> !bus_active);
  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_done |-> $stable(vec_num));
  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !dev_ack && !auto_req && !bus_err) |=> (bus_active && $stable(bus_addr)));
endmodule

bind iack_vector_gen iack_vector_gen_chk #(
  .ADDR_W(ADDR_W), .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ack_start  (ack_start),
  .ack_level  (ack_level),
  .bus_active (bus_active),
  .bus_fc     (bus_fc),
  .bus_addr   (bus_addr),
  .dev_data   (dev_data),
  .dev_ack    (dev_ack),
  .auto_req   (auto_req),
  .bus_err    (bus_err),
  .vec_num    (vec_num),
  .vec_done   (vec_done)
);

// File: tb/iack_vector_gen_tb_top.sv
`timescale 1ns/1ps
module iack_vector_gen_tb_top;
  localparam int ADDR_W = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ack_start = 1'b0;
  logic [2:0]        ack_level = 3'd0;
  logic              bus_active;
  logic [2:0]        bus_fc;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        dev_data = 8'd0;
  logic              dev_ack = 1'b0;
  logic              auto_req = 1'b0;
  logic              bus_err = 1'b0;
  logic [7:0]        vec_num;
  logic              vec_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rel_cnt = 0;
  bit compare_on = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  int m_busy = 0, m_lvl = 0, m_vec = 0, m_done = 0;

  always #10 clk = ~clk;

  iack_vector_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .ack_level(ack_level),
    .bus_active(bus_active), .bus_fc(bus_fc), .bus_addr(bus_addr),
    .dev_data(dev_data), .dev_ack(dev_ack), .auto_req(auto_req), .bus_err(bus_err),
    .vec_num(vec_num), .vec_done(vec_done)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n || rel_cnt < 3) begin
      m_busy = 0; m_lvl = 0; m_vec = 0; m_done = 0;
      rel_cnt = rst_n ? rel_cnt + 1 : 0;
    end else if (m_busy == 0) begin
      m_done = 0;
      if (ack_start && ack_level != 0) begin
        m_busy = 1; m_lvl = ack_level;
      end
    end else begin
      m_done = 0;
      if (bus_err)       begin m_vec = 24;         m_done = 1; m_busy = 0; end
      else if (auto_req) begin m_vec = 24 + m_lvl; m_done = 1; m_busy = 0; end
      else if (dev_ack)  begin m_vec = dev_data;   m_done = 1; m_busy = 0; end
    end
  end

  function automatic logic [ADDR_W-1:0] exp_addr();
    return m_busy ? {{(ADDR_W-3){1'b1}}, 3'(m_lvl)} : '0;
  endfunction

  always @(negedge clk) begin
    if (compare_on && !finished) begin
      checks++;
      if (bus_active !== 1'(m_busy) || bus_fc !== (m_busy ? 3'b111 : 3'b000) ||
          bus_addr !== exp_addr() || vec_num !== 8'(m_vec) || vec_done !== 1'(m_done)) begin
        errors++;
        $display("FAIL %s cyc %0d: act act=%0b fc=%0h addr=%0h vec=%0d done=%0b exp act=%0d fc=%0h addr=%0h vec=%0d done=%0d",
                 cur_tag, cyc, bus_active, bus_fc, bus_addr, vec_num, vec_done,
                 m_busy, m_busy ? 7 : 0, exp_addr(), m_vec, m_done);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: act cyc=%0d exp end before 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic direct(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // runs one acknowledge; checks the done strobe and vector directly
  task automatic run_iack(input string tag, input int lvl, input int stall,
                          input bit e, input bit a, input bit d, input int data);
    int expv;
    cur_tag = tag;
    @(negedge clk);
    ack_start = 1'b1; ack_level = 3'(lvl);
    @(negedge clk);
    ack_start = 1'b0; ack_level = 3'd0;
    direct(tag, bus_active === 1'b1 && bus_addr[2:0] === 3'(lvl), int'(bus_addr[2:0]), lvl);
    idle(stall);
    dev_data = 8'(data); bus_err = e; auto_req = a; dev_ack = d;
    @(negedge clk);
    bus_err = 1'b0; auto_req = 1'b0; dev_ack = 1'b0; dev_data = 8'hA5;
    expv = e ? 24 : (a ? 24 + lvl : data);
    direct(tag, vec_done === 1'b1 && vec_num === 8'(expv), int'(vec_num), expv);
    direct(tag, bus_active === 1'b0, int'(bus_active), 0);
    @(negedge clk);
    direct({tag, " R8"}, vec_done === 1'b0 && vec_num === 8'(expv), int'(vec_num), expv);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    direct("R1", bus_active === 1'b0 && bus_fc === 3'b000 && bus_addr === '0 &&
           vec_num === 8'd0 && vec_done === 1'b0, int'(vec_num), 0);
    rst_n = 1'b1;
    idle(6);
    compare_on = 1'b1;
    direct("R1", bus_active === 1'b0 && vec_done === 1'b0, int'(bus_active), 0);

    // R3 level 0 ignored
    cur_tag = "R3";
    ack_start = 1'b1; ack_level = 3'd0;
    @(negedge clk);
    ack_start = 1'b0;
    direct("R3", bus_active === 1'b0 && bus_fc === 3'b000, int'(bus_active), 0);
    idle(2);

    // R2 R4 device byte
    run_iack("R4", 3, 0, 0, 0, 1, 8'h40);
    run_iack("R2", 7, 2, 0, 0, 1, 8'hFF);
    // R5 auto-vector, data ignored
    run_iack("R5", 1, 1, 0, 1, 0, 8'h99);
    run_iack("R5", 7, 0, 0, 1, 0, 8'h12);
    // R6 spurious
    run_iack("R6", 5, 3, 1, 0, 0, 8'h77);
    // R7 priority combos
    run_iack("R7", 4, 0, 1, 1, 1, 8'h33);
    run_iack("R7", 6, 0, 0, 1, 1, 8'h44);
    run_iack("R7", 2, 0, 1, 0, 1, 8'h55);
    run_iack("R7", 3, 0, 1, 1, 0, 8'h66);

    // R9 start during open cycle ignored
    cur_tag = "R9";
    ack_start = 1'b1; ack_level = 3'd2;
    @(negedge clk);
    ack_level = 3'd6;
    @(negedge clk);
    ack_start = 1'b0; ack_level = 3'd0;
    direct("R9", bus_addr[2:0] === 3'd2, int'(bus_addr[2:0]), 2);
    auto_req = 1'b1;
    @(negedge clk);
    auto_req = 1'b0;
    direct("R9", vec_num === 8'd26, int'(vec_num), 26);
    idle(2);

    // R10 long stall
    cur_tag = "R10";
    ack_start = 1'b1; ack_level = 3'd4;
    @(negedge clk);
    ack_start = 1'b0;
    idle(60);
    direct("R10", bus_active === 1'b1 && vec_done === 1'b0, int'(bus_active), 1);
    dev_data = 8'h10; dev_ack = 1'b1;
    @(negedge clk);
    dev_ack = 1'b0;
    direct("R10", vec_num === 8'h10 && vec_done === 1'b1, int'(vec_num), 16);
    idle(4);

    // back-to-back: new start in the cycle after done
    run_iack("R8", 1, 0, 0, 0, 1, 8'h01);
    run_iack("R8", 2, 0, 1, 0, 0, 8'h02);
    idle(3);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule